// File: doc/BRIEF.md
# MAC Address Lookup Table Engine

This block holds a small table of MAC address entries for a switch with three ports and answers destination lookups against it. Software reaches the table indirectly through a register window. It writes the three 32-bit staging words and then commits them to an entry index, or it names an index to pull that entry into the staging words. A control register enables the engine and can wipe the whole table. One register per port holds that port's forwarding state.

The lookup side takes a destination MAC address and the ingress port. It walks the table one entry per cycle and returns a port mask with a hit flag and a single-cycle done pulse. A unicast hit gives a one-hot mask. A multicast hit gives the entry's stored mask. Both are limited to ports that are currently forwarding. A miss floods to every forwarding port except the one the frame came in on. A wipe starts on its own at reset, so the table never holds undefined content.

Top module: `swl_engine`

## Requirements
- R1: During reset and for N_ENTRIES cycles after it, the engine wipes every entry to free (type 0). After reset the control register reads with only bit 30 (wipe running) set, every port register reads 0 (disabled), and lk_busy and lk_done are low.
- R2: An entry is 96 bits wide, held as three staging words at offsets 0x34, 0x38 and 0x3C. The word at 0x34 holds entry bits 95:64, 0x38 holds bits 63:32 and 0x3C holds bits 31:0. A committed entry reads back unchanged.
- R3: A write to the table control register at 0x20 with bit 31 set commits the staging words to the entry whose index is in the low bits. With bit 31 clear, the same write loads that entry into the staging words. The register reads back the last index written.
- R4: Control register 0x08: bit 31 enables lookups and bit 2 is a stored mode flag. Writing bit 30 wipes all entries, one per cycle. Bit 30 reads 1 while the wipe runs and drops by itself after N_ENTRIES cycles.
- R5: The port p register is at 0x40+4p for p in 0..2. Its bits 1:0 hold the state: 0 disabled, 1 blocking, 2 learning, 3 forwarding. Writes to 0x4C change no port.
- R6: A lookup considers only entries of type 1 or 3 (bits 61:60), compares the MAC in bits 47:0, and reports the lowest-index match. A match at index i raises lk_done i+1 cycles after the request is taken.
- R7: A hit on a unicast entry (bit 40 clear) returns lk_hit=1 and a one-hot mask of the port in bits 67:66, provided that port is forwarding.
- R8: A unicast hit whose blocked bit (65) is set, or whose port is not forwarding, returns lk_hit=1 with an empty mask.
- R9: A hit on a multicast entry (bit 40 set) returns the 3-bit mask from bits 68:66 ANDed with the set of forwarding ports.
- R10: A miss returns lk_hit=0 and a mask of all forwarding ports except the ingress port, N_ENTRIES cycles after the request is taken.
- R11: A lookup requested while a wipe runs, or in the same cycle a wipe starts, waits and then scans the wiped table. A commit issued while a wipe runs is dropped.
- R12: With the engine disabled, a lookup completes one cycle after it is taken, with lk_hit=0 and an empty mask.
- R13: lk_done is a one-cycle pulse. lk_busy is high from the cycle after a request is taken until done, and requests made while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe; data is valid the next cycle |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| lk_req | input | 1 | Lookup request |
| lk_mac | input | 48 | Destination MAC address to look up |
| lk_ingress | input | 2 | Port the frame arrived on |
| lk_busy | output | 1 | A lookup is pending or scanning |
| lk_done | output | 1 | One-cycle result strobe |
| lk_hit | output | 1 | The address matched an entry |
| lk_mask | output | 3 | Destination port mask |

## Verification
Two functions share the table: a software-started wipe and a lookup scan. They can fall on the same cycle. The bench provokes this by driving the wipe write and a lookup request on the same clock edge. It then judges the outcome in two ways. The lookup must finish exactly one wipe length plus one full miss scan later. It must report a flooded miss, because the entry it would have hit is gone. A second run commits an entry during a wipe and then shows that the address still misses.

// File: rtl/swl_pkg.sv
package swl_pkg;
  localparam int WORD_W   = 32;
  localparam int N_WORDS  = 3;
  localparam int ENTRY_W  = WORD_W * N_WORDS;
  localparam int N_PORTS  = 3;

  typedef enum logic [1:0] {
    PS_OFF   = 2'd0,
    PS_BLOCK = 2'd1,
    PS_LEARN = 2'd2,
    PS_FWD   = 2'd3
  } port_state_e;

  localparam logic [1:0] TY_FREE  = 2'd0;
  localparam logic [1:0] TY_ADDR  = 2'd1;
  localparam logic [1:0] TY_VLAN  = 2'd2;
  localparam logic [1:0] TY_VADDR = 2'd3;

  function automatic logic [1:0] ent_type(input logic [ENTRY_W-1:0] e);
    return e[61:60];
  endfunction

  function automatic logic [47:0] ent_mac(input logic [ENTRY_W-1:0] e);
    return e[47:0];
  endfunction

  function automatic logic ent_is_mcast(input logic [ENTRY_W-1:0] e);
    return e[40];
  endfunction

  function automatic logic ent_blocked(input logic [ENTRY_W-1:0] e);
    return e[65];
  endfunction

  function automatic logic [1:0] ent_port(input logic [ENTRY_W-1:0] e);
    return e[67:66];
  endfunction

  function automatic logic [N_PORTS-1:0] ent_pmask(input logic [ENTRY_W-1:0] e);
    return e[68:66];
  endfunction
endpackage

// File: rtl/swl_table.sv
module swl_table
  import swl_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr_start,
  input  logic               st_en,
  input  logic [IDX_W-1:0]   st_idx,
  input  logic [ENTRY_W-1:0] st_data,
  input  logic [IDX_W-1:0]   rd_idx_a,
  output logic [ENTRY_W-1:0] rd_data_a,
  input  logic [IDX_W-1:0]   rd_idx_b,
  output logic [ENTRY_W-1:0] rd_data_b,
  output logic               clr_busy
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ENTRIES - 1);

  logic [ENTRY_W-1:0] mem [N_ENTRIES];
  logic [IDX_W-1:0]   clr_idx;
  logic               wr_en;
  logic [IDX_W-1:0]   wr_idx;
  logic [ENTRY_W-1:0] wr_data;

  // wipe owns the single write port while it runs
  always_comb begin
    wr_en   = clr_busy | st_en;
    wr_idx  = clr_busy ? clr_idx : st_idx;
    wr_data = clr_busy ? '0 : st_data;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data_a = mem[rd_idx_a];
  assign rd_data_b = mem[rd_idx_b];

  always_ff @(posedge clk) begin
    if (rst) begin
      clr_busy <= 1'b1;
      clr_idx  <= '0;
    end else if (clr_busy) begin
      if (clr_idx == LAST_IDX) clr_busy <= 1'b0;
      else                     clr_idx  <= clr_idx + 1'b1;
    end else if (clr_start) begin
      clr_busy <= 1'b1;
      clr_idx  <= '0;
    end
  end
endmodule

// File: rtl/swl_port_ctl.sv
module swl_port_ctl
  import swl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [1:0]           sel,
  input  logic [1:0]           state_in,
  output logic [2*N_PORTS-1:0] states,
  output logic [N_PORTS-1:0]   fwd_set
);
  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    port_state_e st;
    always_ff @(posedge clk) begin
      if (rst)                          st <= PS_OFF;
      else if (we && sel == 2'(p))      st <= port_state_e'(state_in);
    end
    assign states[2*p +: 2] = st;
    assign fwd_set[p]       = (st == PS_FWD);
  end
endmodule

// File: rtl/swl_search.sv
module swl_search
  import swl_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req,
  input  logic [47:0]        mac,
  input  logic [1:0]         ingress,
  input  logic               eng_en,
  input  logic               hold,
  input  logic [N_PORTS-1:0] fwd_set,
  input  logic [ENTRY_W-1:0] ent,
  output logic [IDX_W-1:0]   idx,
  output logic               busy,
  output logic               scanning,
  output logic [1:0]         lat_ing,
  output logic               done,
  output logic               hit,
  output logic [N_PORTS-1:0] mask
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ENTRIES - 1);

  typedef enum logic [1:0] {SR_IDLE, SR_WAIT, SR_SCAN} sr_state_e;
  sr_state_e           state;
  logic [47:0]         lat_mac;
  logic                match;
  logic [N_PORTS-1:0]  hit_mask;
  logic [N_PORTS-1:0]  flood_mask;
  logic                unused_fields;

  assign unused_fields = ^{ent[ENTRY_W-1:69], ent[64:62], ent[59:48]};

  always_comb begin
    match = ((ent_type(ent) == TY_ADDR) || (ent_type(ent) == TY_VADDR)) &&
            (ent_mac(ent) == lat_mac);
    if (ent_is_mcast(ent))
      hit_mask = ent_pmask(ent) & fwd_set;
    else if (ent_blocked(ent))
      hit_mask = '0;
    else
      hit_mask = (N_PORTS'(1) << ent_port(ent)) & fwd_set;
    flood_mask = fwd_set & ~(N_PORTS'(1) << lat_ing);
  end

  assign busy     = (state != SR_IDLE);
  assign scanning = (state == SR_SCAN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SR_IDLE;
      idx     <= '0;
      lat_mac <= '0;
      lat_ing <= '0;
      done    <= 1'b0;
      hit     <= 1'b0;
      mask    <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        SR_IDLE: if (req) begin
          lat_mac <= mac;
          lat_ing <= ingress;
          idx     <= '0;
          state   <= hold ? SR_WAIT : SR_SCAN;
        end
        SR_WAIT: if (!hold) state <= SR_SCAN;
        SR_SCAN: begin
          if (hold) begin
            idx   <= '0;
            state <= SR_WAIT;
          end else if (!eng_en) begin
            done  <= 1'b1;
            hit   <= 1'b0;
            mask  <= '0;
            state <= SR_IDLE;
          end else if (match) begin
            done  <= 1'b1;
            hit   <= 1'b1;
            mask  <= hit_mask;
            state <= SR_IDLE;
          end else if (idx == LAST_IDX) begin
            done  <= 1'b1;
            hit   <= 1'b0;
            mask  <= flood_mask;
            state <= SR_IDLE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: state <= SR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/swl_engine.sv
module swl_engine
  import swl_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              lk_req,
  input  logic [47:0]       lk_mac,
  input  logic [1:0]        lk_ingress,
  output logic              lk_busy,
  output logic              lk_done,
  output logic              lk_hit,
  output logic [2:0]        lk_mask
);
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;
  localparam int OFS_CTRL = 'h08;
  localparam int OFS_TCTL = 'h20;
  localparam int OFS_WRD0 = 'h34;
  localparam int OFS_PRT0 = 'h40;

  logic                 eng_en, mode_flag;
  logic                 clr_busy, clr_start;
  logic                 ctrl_we, tctl_we, st_en;
  logic [IDX_W-1:0]     tbl_idx, scan_idx;
  logic [ENTRY_W-1:0]   stage, rd_a, rd_b;
  logic                 port_we;
  logic [1:0]           port_sel;
  logic [2*N_PORTS-1:0] port_st;
  logic [N_PORTS-1:0]   fwd_set;
  logic                 scanning;
  logic [1:0]           lat_ing;
  logic [31:0]          rd_mux;

  assign ctrl_we   = reg_we && (reg_addr == ADDR_W'(OFS_CTRL));
  assign tctl_we   = reg_we && (reg_addr == ADDR_W'(OFS_TCTL));
  assign clr_start = ctrl_we && reg_wdata[30] && !clr_busy;
  assign st_en     = tctl_we && reg_wdata[31] && !clr_busy;

  always_comb begin
    port_we  = 1'b0;
    port_sel = '0;
    for (int p = 0; p < N_PORTS; p++) begin
      if (reg_we && reg_addr == ADDR_W'(OFS_PRT0 + 4*p)) begin
        port_we  = 1'b1;
        port_sel = 2'(p);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eng_en    <= 1'b0;
      mode_flag <= 1'b0;
      tbl_idx   <= '0;
      stage     <= '0;
    end else begin
      if (ctrl_we) begin
        eng_en    <= reg_wdata[31];
        mode_flag <= reg_wdata[2];
      end
      if (tctl_we) begin
        tbl_idx <= reg_wdata[IDX_W-1:0];
        if (!reg_wdata[31]) stage <= rd_a;
      end
      for (int w = 0; w < N_WORDS; w++) begin
        if (reg_we && reg_addr == ADDR_W'(OFS_WRD0 + 4*w))
          stage[ENTRY_W-1-WORD_W*w -: WORD_W] <= reg_wdata;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr == ADDR_W'(OFS_CTRL))
      rd_mux = {eng_en, clr_busy, 27'd0, mode_flag, 2'd0};
    if (reg_addr == ADDR_W'(OFS_TCTL))
      rd_mux = 32'(tbl_idx);
    for (int w = 0; w < N_WORDS; w++)
      if (reg_addr == ADDR_W'(OFS_WRD0 + 4*w))
        rd_mux = stage[ENTRY_W-1-WORD_W*w -: WORD_W];
    for (int p = 0; p < N_PORTS; p++)
      if (reg_addr == ADDR_W'(OFS_PRT0 + 4*p))
        rd_mux = {30'd0, port_st[2*p +: 2]};
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_re) reg_rdata <= rd_mux;
  end

  swl_table #(.N_ENTRIES(N_ENTRIES)) i_table (
    .clk(clk), .rst(rst), .clr_start(clr_start),
    .st_en(st_en), .st_idx(reg_wdata[IDX_W-1:0]), .st_data(stage),
    .rd_idx_a(reg_wdata[IDX_W-1:0]), .rd_data_a(rd_a),
    .rd_idx_b(scan_idx), .rd_data_b(rd_b),
    .clr_busy(clr_busy)
  );

  swl_port_ctl i_ports (
    .clk(clk), .rst(rst), .we(port_we), .sel(port_sel),
    .state_in(reg_wdata[1:0]), .states(port_st), .fwd_set(fwd_set)
  );

  swl_search #(.N_ENTRIES(N_ENTRIES)) i_search (
    .clk(clk), .rst(rst), .req(lk_req), .mac(lk_mac), .ingress(lk_ingress),
    .eng_en(eng_en), .hold(clr_busy | clr_start), .fwd_set(fwd_set),
    .ent(rd_b), .idx(scan_idx), .busy(lk_busy), .scanning(scanning),
    .lat_ing(lat_ing), .done(lk_done), .hit(lk_hit), .mask(lk_mask)
  );
endmodule

// File: rtl/swl_engine_chk.sv
module swl_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic       lk_done,
  input logic       lk_busy,
  input logic       lk_hit,
  input logic [2:0] lk_mask,
  input logic [2:0] fwd_set,
  input logic       clr_busy,
  input logic       scanning,
  input logic [1:0] lat_ing,
  input logic       eng_en
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    lk_done |=> !lk_done); // R13
  AST_DONE_FREES_BUSY: assert property (@(posedge clk) disable iff (rst)
    lk_done |-> !lk_busy); // R13
  AST_MASK_IN_FWD: assert property (@(posedge clk) disable iff (rst)
    lk_done |-> ((lk_mask & ~$past(fwd_set)) == 3'b000)); // R9
  AST_MISS_SKIPS_INGRESS: assert property (@(posedge clk) disable iff (rst)
    (lk_done && !lk_hit) |-> ((lk_mask & (3'b001 << lat_ing)) == 3'b000)); // R10
  AST_NO_SCAN_IN_WIPE: assert property (@(posedge clk) disable iff (rst)
    clr_busy |-> !scanning); // R11
  AST_OFF_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (lk_done && !$past(eng_en)) |-> (!lk_hit && lk_mask == 3'b000)); // R12
endmodule

bind swl_engine swl_engine_chk i_chk (
  .clk(clk), .rst(rst), .lk_done(lk_done), .lk_busy(lk_busy),
  .lk_hit(lk_hit), .lk_mask(lk_mask), .fwd_set(fwd_set),
  .clr_busy(clr_busy), .scanning(scanning), .lat_ing(lat_ing),
  .eng_en(eng_en)
);

// File: tb/test_swl_engine.sv
`timescale 1ns/1ps
module test_swl_engine;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        lk_req = 1'b0;
  logic [47:0] lk_mac = '0;
  logic [1:0]  lk_ingress = '0;
  logic        lk_busy, lk_done, lk_hit;
  logic [2:0]  lk_mask;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  swl_engine #(.N_ENTRIES(N), .ADDR_W(8)) i_swl_engine (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lk_req(lk_req), .lk_mac(lk_mac), .lk_ingress(lk_ingress),
    .lk_busy(lk_busy), .lk_done(lk_done), .lk_hit(lk_hit), .lk_mask(lk_mask)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic put_entry(input int idx, input logic [95:0] e);
    wr(8'h34, e[95:64]);
    wr(8'h38, e[63:32]);
    wr(8'h3C, e[31:0]);
    wr(8'h20, 32'h8000_0000 | 32'(idx));
  endtask

  function automatic logic [95:0] mk_uc(input logic [47:0] m, input logic [1:0] port, input logic blk);
    logic [95:0] e = '0;
    e[47:0] = m; e[61:60] = 2'd1; e[65] = blk; e[67:66] = port;
    return e;
  endfunction

  function automatic logic [95:0] mk_mc(input logic [47:0] m, input logic [2:0] pm);
    logic [95:0] e = '0;
    e[47:0] = m; e[61:60] = 2'd1; e[68:66] = pm;
    return e;
  endfunction

  // counts negedges after the request until lk_done is seen
  task automatic lookup(input logic [47:0] m, input logic [1:0] ing,
                        output logic hit, output logic [2:0] mask, output int n);
    @(negedge clk);
    lk_req = 1'b1; lk_mac = m; lk_ingress = ing;
    n = 0;
    @(posedge clk);
    @(negedge clk);
    lk_req = 1'b0;
    n = 1;
    while (!lk_done) begin
      @(posedge clk);
      @(negedge clk);
      n++;
    end
    hit = lk_hit; mask = lk_mask;
    @(negedge clk);
    check("R13 done one cycle", {95'd0, lk_done}, 96'd0);
  endtask

  localparam logic [47:0] MAC_A = 48'h02_11_22_33_44_55;
  localparam logic [47:0] MAC_B = 48'h02_aa_bb_cc_dd_01;
  localparam logic [47:0] MAC_C = 48'h02_aa_bb_cc_dd_02;
  localparam logic [47:0] MAC_D = 48'h01_00_5e_00_00_07;
  localparam logic [47:0] MAC_E = 48'h02_de_ad_00_00_09;
  localparam logic [47:0] MAC_F = 48'h02_f0_f0_f0_f0_f0;

  task automatic t_reset();
    logic [31:0] d;
    check("R1 busy after reset", {95'd0, lk_busy}, 96'd0);
    check("R1 done after reset", {95'd0, lk_done}, 96'd0);
    rd(8'h08, d);
    check("R1 ctrl shows wipe", 96'(d), 96'h4000_0000);
    rd(8'h44, d);
    check("R1 port disabled", 96'(d), 96'd0);
    repeat (N + 2) @(negedge clk);
    rd(8'h08, d);
    check("R4 wipe bit self clears", 96'(d), 96'd0);
    wr(8'h20, 32'd5);
    rd(8'h3C, d);
    check("R1 entry free", 96'(d), 96'd0);
  endtask

  task automatic t_store_load();
    logic [31:0] d0, d1, d2;
    logic [95:0] e = 96'h0000_0005_1234_5678_9abc_def0;
    put_entry(3, e);
    wr(8'h20, 32'd0);
    wr(8'h20, 32'd3);
    rd(8'h34, d0); rd(8'h38, d1); rd(8'h3C, d2);
    check("R2 word order", {d0, d1, d2}, e);
    check("R2 low word holds bits 31:0", 96'(d2), 96'(e[31:0]));
    rd(8'h20, d0);
    check("R3 index readback", 96'(d0), 96'd3);
    put_entry(3, '0);
  endtask

  task automatic t_ports();
    logic [31:0] d;
    wr(8'h40, 32'd3); wr(8'h44, 32'd3); wr(8'h48, 32'd3);
    wr(8'h4C, 32'd1);
    rd(8'h44, d);
    check("R5 port1 forwarding", 96'(d), 96'd3);
    rd(8'h48, d);
    check("R5 write to 0x4C ignored", 96'(d), 96'd3);
    wr(8'h08, 32'h8000_0004);
    rd(8'h08, d);
    check("R4 enable and mode flag", 96'(d), 96'h8000_0004);
  endtask

  task automatic t_ucast();
    logic h; logic [2:0] m; int n;
    logic [95:0] v = mk_uc(MAC_A, 2'd0, 1'b0);
    v[61:60] = 2'd2;
    put_entry(2, v);
    put_entry(4, mk_uc(MAC_A, 2'd2, 1'b0));
    put_entry(6, mk_uc(MAC_A, 2'd1, 1'b0));
    lookup(MAC_A, 2'd0, h, m, n);
    check("R7 unicast hit", {92'd0, h, m}, {92'd0, 1'b1, 3'b100});
    check("R6 first match latency", 96'(n), 96'd6);
  endtask

  task automatic t_blocked();
    logic h; logic [2:0] m; int n;
    put_entry(7, mk_uc(MAC_B, 2'd1, 1'b1));
    lookup(MAC_B, 2'd0, h, m, n);
    check("R8 blocked entry", {92'd0, h, m}, {92'd0, 1'b1, 3'b000});
    put_entry(8, mk_uc(MAC_C, 2'd0, 1'b0));
    wr(8'h40, 32'd2);
    lookup(MAC_C, 2'd1, h, m, n);
    check("R8 learning port", {92'd0, h, m}, {92'd0, 1'b1, 3'b000});
    wr(8'h40, 32'd3);
    lookup(MAC_C, 2'd1, h, m, n);
    check("R7 port0 forwarding", {92'd0, h, m}, {92'd0, 1'b1, 3'b001});
  endtask

  task automatic t_mcast();
    logic h; logic [2:0] m; int n;
    put_entry(9, mk_mc(MAC_D, 3'b111));
    wr(8'h48, 32'd1);
    lookup(MAC_D, 2'd0, h, m, n);
    check("R9 multicast masked", {92'd0, h, m}, {92'd0, 1'b1, 3'b011});
    wr(8'h48, 32'd3);
  endtask

  task automatic t_miss();
    logic h; logic [2:0] m; int n;
    lookup(MAC_E, 2'd1, h, m, n);
    check("R10 miss flood", {92'd0, h, m}, {92'd0, 1'b0, 3'b101});
    check("R10 miss latency", 96'(n), 96'(N + 1));
    lookup(MAC_E, 2'd3, h, m, n);
    check("R10 miss from port 3", {92'd0, h, m}, {92'd0, 1'b0, 3'b111});
  endtask

  task automatic t_disabled();
    logic h; logic [2:0] m; int n;
    wr(8'h08, 32'h0);
    lookup(MAC_A, 2'd0, h, m, n);
    check("R12 disabled result", {92'd0, h, m}, 96'd0);
    check("R12 disabled latency", 96'(n), 96'd2);
    wr(8'h08, 32'h8000_0000);
  endtask

  task automatic t_busy_ignore();
    int n;
    @(negedge clk);
    lk_req = 1'b1; lk_mac = MAC_E; lk_ingress = 2'd0;
    @(posedge clk);
    @(negedge clk);
    lk_mac = MAC_A;
    check("R13 busy after take", {95'd0, lk_busy}, 96'd1);
    n = 1;
    while (!lk_done) begin
      @(posedge clk);
      @(negedge clk);
      n++;
    end
    lk_req = 1'b0;
    check("R13 second request ignored", {92'd0, lk_hit, lk_mask}, {92'd0, 1'b0, 3'b110});
    @(negedge clk);
  endtask

  task automatic t_collide();
    logic h; logic [2:0] m; int n;
    logic [31:0] d;
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 8'h08; reg_wdata = 32'hC000_0000;
    lk_req = 1'b1; lk_mac = MAC_A; lk_ingress = 2'd2;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0; lk_req = 1'b0;
    n = 1;
    while (!lk_done) begin
      @(posedge clk);
      @(negedge clk);
      n++;
    end
    check("R11 held lookup misses", {92'd0, lk_hit, lk_mask}, {92'd0, 1'b0, 3'b011});
    check("R11 held lookup latency", 96'(n), 96'(2*N + 2));
    rd(8'h08, d);
    check("R4 wipe done", 96'(d), 96'h8000_0000);
    wr(8'h08, 32'hC000_0000);
    put_entry(1, mk_uc(MAC_F, 2'd0, 1'b0));
    repeat (N) @(negedge clk);
    lookup(MAC_F, 2'd0, h, m, n);
    check("R11 commit during wipe dropped", {92'd0, h, m}, {92'd0, 1'b0, 3'b110});
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_store_load();
    t_ports();
    t_ucast();
    t_blocked();
    t_mcast();
    t_miss();
    t_disabled();
    t_busy_ignore();
    t_collide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule